// File: doc/BRIEF.md
# Polled-Write I2C Memory Target Front End

This block is the bus-facing half of a small serial memory. It watches an oversampled I2C clock and data pair in the system clock domain, detects START, repeated START and STOP, recognises its own 7-bit device address, and shifts bytes in and out with the acknowledge handshake. Behind it sits a memory controller that sees only byte-level events: a transaction start carrying the direction bit, a strobe for each received byte with a flag marking the first byte after the address, a request for the next byte to send, and a STOP indication.

The device address is a fixed five-bit prefix followed by two strap inputs, so four such targets can share a bus. While the memory controller reports an internal write cycle through the busy input, the block refuses every acknowledge, including its own address. A master therefore learns that a write cycle has ended by repeating START plus address until the address is acknowledged. SDA is never driven high; the block only pulls it low through an open-drain enable.

Top module: `i2cEepromTarget`

## Requirements
- R1: After reset the SDA pull-down is released and no transaction, byte, read-request or stop strobe is active.
- R2: SDA rising while SCL is high is a STOP; it pulses stopSeen for one cycle and returns the block to idle from any state, including the middle of a byte.
- R3: A START followed by the address whose seven bits, MSB first, are 1,0,1,0,0 then strapSel[1], strapSel[0] is acknowledged by pulling SDA low in the ninth clock; txnStart pulses once with txnRead equal to the eighth bit (0 write, 1 read).
- R4: An address that does not match gets no acknowledge and no txnStart, and all later bytes up to the next START or STOP are neither acknowledged nor reported.
- R5: While busy is high at the end of the address byte, the address is not acknowledged and txnStart does not pulse.
- R6: In a write, each received byte (MSB first) is acknowledged and reported by one rxValid pulse with the byte on rxData; rxFirst is 1 only for the first byte after the address.
- R7: In a read, rdReq pulses once when the read address is accepted and once after each master ACK; the byte on rdData at the following SCL fall is sent MSB first.
- R8: After a master NACK on a read byte the block drives nothing until the next START or STOP.
- R9: A repeated START after a write address and data must be accepted; a following matching read address starts a read transaction with txnRead equal to 1.
- R10: The SDA pull-down is only asserted after the synchronised SCL has gone low.
- R11: A START in any state restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| strapSel | input | 2 | Strap bits forming the two low address bits |
| busy | input | 1 | High while the internal write cycle runs |
| rdData | input | 8 | Next byte to transmit, valid from the cycle after rdReq |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| txnStart | output | 1 | One-cycle pulse when the address is accepted |
| txnRead | output | 1 | Direction bit of the accepted transaction |
| rxValid | output | 1 | One-cycle pulse per received write byte |
| rxData | output | 8 | Received byte, valid with rxValid |
| rxFirst | output | 1 | Set with rxValid for the first byte after the address |
| rdReq | output | 1 | One-cycle request for the next read byte |
| stopSeen | output | 1 | One-cycle pulse on a STOP condition |

## Verification
The assertions assume that each SCL level lasts several system clocks, longer than the synchroniser plus one register, and that the master moves SDA only while SCL is low except to form START and STOP. They further assume busy is steady across the end of an address byte. The bench master holds every SCL phase for ten clocks, changes SDA two clocks after SCL falls, and changes busy only between transactions, so every check runs inside those limits.

// File: rtl/i2cTgtPkg.sv
package i2cTgtPkg;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = $clog2(BYTE_W + 1);
  localparam int DEV_ADDR_W = 7;

  typedef struct packed {
    logic clrCnt;    // restart the bit counter
    logic sampleRx;  // shift the synchronised SDA into the byte register
    logic loadTx;    // load a read byte and present its MSB
    logic shiftTx;   // move to the next read bit
    logic setAck;    // pull SDA low for an acknowledge
    logic relSda;    // let SDA float
  } dpCtl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_WR_BYTE, S_WR_ACK, S_RD_BYTE, S_RD_ACK, S_WAIT
  } tgtState_t;
endpackage

// File: rtl/i2cTgtDatapath.sv
module i2cTgtDatapath
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdData,
  input  dpCtl_t            ctl,
  output logic              sclRise,
  output logic              sclFall,
  output logic              evStart,
  output logic              evStop,
  output logic              sdaS,
  output logic [BYTE_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              driveLow
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sclQ, sdaQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclS;
      sdaQ    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign evStart = sclS & sclQ & sdaQ & ~sdaS;
  assign evStop  = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      driveLow <= 1'b0;
    end else begin
      if (ctl.loadTx)        shiftReg <= rdData;
      else if (ctl.shiftTx)  shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
      else if (ctl.sampleRx) shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};

      if (ctl.clrCnt)                        bitCnt <= '0;
      else if (ctl.sampleRx || ctl.shiftTx)  bitCnt <= bitCnt + 1'b1;

      if (ctl.setAck)       driveLow <= 1'b1;
      else if (ctl.loadTx)  driveLow <= ~rdData[BYTE_W-1];
      else if (ctl.shiftTx) driveLow <= ~shiftReg[BYTE_W-2];
      else if (ctl.relSda)  driveLow <= 1'b0;
    end
  end

  // R10: the pull-down only engages once the synchronised clock is low
  a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> !sclQ);
endmodule

// File: rtl/i2cTgtControl.sv
module i2cTgtControl
  import i2cTgtPkg::*;
#(
  parameter int STRAP_W = 2,
  parameter logic [DEV_ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 5'b10100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               evStart,
  input  logic               evStop,
  input  logic               sdaS,
  input  logic [BYTE_W-1:0]  shiftReg,
  input  logic [CNT_W-1:0]   bitCnt,
  input  logic [STRAP_W-1:0] strapSel,
  input  logic               busy,
  output dpCtl_t             ctl,
  output logic               txnStart,
  output logic               txnRead,
  output logic               rxValid,
  output logic               rxFirst,
  output logic               rdReq,
  output logic               stopSeen
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

  tgtState_t state, nxt;
  logic rwBit, firstPend, ackOk, addrMatch, byteDone;

  assign addrMatch = (shiftReg[BYTE_W-1:1] == {ADDR_PREFIX, strapSel});
  assign byteDone  = (bitCnt == FULL_CNT);

  always_comb begin
    nxt      = state;
    ctl      = '0;
    txnStart = 1'b0;
    rxValid  = 1'b0;
    rdReq    = 1'b0;
    stopSeen = 1'b0;
    if (evStop) begin
      nxt = S_IDLE;  ctl.relSda = 1'b1;  stopSeen = 1'b1;
    end else if (evStart) begin
      nxt = S_ADDR;  ctl.relSda = 1'b1;  ctl.clrCnt = 1'b1;
    end else begin
      unique case (state)
        S_ADDR: begin
          ctl.sampleRx = sclRise;
          if (sclFall && byteDone) begin
            if (addrMatch && !busy) begin
              nxt = S_ADDR_ACK;  ctl.setAck = 1'b1;  txnStart = 1'b1;
              rdReq = shiftReg[0];
            end else begin
              nxt = S_WAIT;  ctl.relSda = 1'b1;
            end
          end
        end
        S_ADDR_ACK: if (sclFall) begin
          ctl.clrCnt = 1'b1;
          if (rwBit) begin nxt = S_RD_BYTE;  ctl.loadTx = 1'b1; end
          else       begin nxt = S_WR_BYTE;  ctl.relSda = 1'b1; end
        end
        S_WR_BYTE: begin
          ctl.sampleRx = sclRise;
          if (sclFall && byteDone) begin
            if (busy) begin nxt = S_WAIT;  ctl.relSda = 1'b1; end
            else begin nxt = S_WR_ACK;  ctl.setAck = 1'b1;  rxValid = 1'b1; end
          end
        end
        S_WR_ACK: if (sclFall) begin
          nxt = S_WR_BYTE;  ctl.relSda = 1'b1;  ctl.clrCnt = 1'b1;
        end
        S_RD_BYTE: if (sclFall) begin
          if (bitCnt == LAST_CNT) begin nxt = S_RD_ACK;  ctl.relSda = 1'b1; end
          else ctl.shiftTx = 1'b1;
        end
        S_RD_ACK: begin
          rdReq = sclRise & ~sdaS;
          if (sclFall) begin
            if (ackOk) begin nxt = S_RD_BYTE;  ctl.loadTx = 1'b1;  ctl.clrCnt = 1'b1; end
            else       begin nxt = S_WAIT;  ctl.relSda = 1'b1; end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      rwBit     <= 1'b0;
      firstPend <= 1'b0;
      ackOk     <= 1'b0;
    end else begin
      state <= nxt;
      if (txnStart) begin
        rwBit     <= shiftReg[0];
        firstPend <= 1'b1;
      end else if (rxValid) begin
        firstPend <= 1'b0;
      end
      if (state == S_RD_ACK && sclRise) ackOk <= ~sdaS;
    end
  end

  assign txnRead = txnStart ? shiftReg[0] : rwBit;
  assign rxFirst = firstPend;

  // R2: a STOP always lands in idle
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (state == S_IDLE));
  // R5: no transaction is opened while the write cycle runs
  a_r5_busy_blocks_txn: assert property (@(posedge clk) disable iff (!rstN)
    txnStart |-> !busy);
  // R1: controller strobes never coincide
  a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txnStart, rxValid, stopSeen}));
  // R8: after a master NACK nothing is requested
  a_r8_wait_no_request: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT) |-> !rdReq);
endmodule

// File: rtl/i2cEepromTarget.sv
module i2cEepromTarget
  import i2cTgtPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W = 2,
  parameter logic [DEV_ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 5'b10100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapSel,
  input  logic               busy,
  input  logic [BYTE_W-1:0]  rdData,
  output logic               sdaDriveLow,
  output logic               txnStart,
  output logic               txnRead,
  output logic               rxValid,
  output logic [BYTE_W-1:0]  rxData,
  output logic               rxFirst,
  output logic               rdReq,
  output logic               stopSeen
);
  dpCtl_t ctl;
  logic sclRise, sclFall, evStart, evStop, sdaS;
  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  i2cTgtDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .rdData(rdData),
    .ctl(ctl), .sclRise(sclRise), .sclFall(sclFall), .evStart(evStart),
    .evStop(evStop), .sdaS(sdaS), .shiftReg(shiftReg), .bitCnt(bitCnt),
    .driveLow(sdaDriveLow)
  );

  i2cTgtControl #(.STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .evStart(evStart), .evStop(evStop), .sdaS(sdaS), .shiftReg(shiftReg),
    .bitCnt(bitCnt), .strapSel(strapSel), .busy(busy), .ctl(ctl),
    .txnStart(txnStart), .txnRead(txnRead), .rxValid(rxValid),
    .rxFirst(rxFirst), .rdReq(rdReq), .stopSeen(stopSeen)
  );

  assign rxData = shiftReg;

  // R3: an accepted address is followed by the acknowledge pull-down
  a_r3_ack_after_match: assert property (@(posedge clk) disable iff (!rstN)
    txnStart |=> sdaDriveLow);
  // R6: every reported write byte is acknowledged
  a_r6_byte_acked: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> sdaDriveLow);
endmodule

// File: tb/test_i2cEepromTarget.sv
module test_i2cEepromTarget;
  localparam int H = 10;
  localparam int EV_TXN = 1024, EV_RX = 2048, EV_STOP = 3072;

  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [1:0] strapSel = 2'b10;
  logic busy = 1'b0;
  logic [7:0] rdData = 8'h00;
  logic sdaIn, sdaDriveLow, txnStart, txnRead, rxValid, rxFirst, rdReq, stopSeen;
  logic [7:0] rxData;

  int checks = 0, failures = 0, rdPtr = 0;
  int evQ[$];
  logic [7:0] memModel [4] = '{8'h3C, 8'h81, 8'hF0, 8'h55};

  always #4 clk = ~clk;
  assign sdaIn = sdaM & ~sdaDriveLow;

  i2cEepromTarget i_i2cEepromTarget (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaIn), .strapSel(strapSel),
    .busy(busy), .rdData(rdData), .sdaDriveLow(sdaDriveLow), .txnStart(txnStart),
    .txnRead(txnRead), .rxValid(rxValid), .rxData(rxData), .rxFirst(rxFirst),
    .rdReq(rdReq), .stopSeen(stopSeen)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic matchEv(input int code, input string req);
    if (evQ.size() == 0) check(1'b0, req, code, -1);
    else begin
      int e;
      e = evQ.pop_front();
      check(e == code, req, code, e);
    end
  endtask

  // reference model: expected strobe stream, compared on every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (txnStart) matchEv(EV_TXN + int'(txnRead), "R3");
      if (rxValid)  matchEv(EV_RX + (rxFirst ? 256 : 0) + int'(rxData), "R6");
      if (stopSeen) matchEv(EV_STOP, "R2");
      if (rdReq) begin
        rdData = memModel[rdPtr % 4];
        rdPtr  = rdPtr + 1;
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0;
  endtask

  task automatic repStart();
    waitClk(2); sdaM = 1'b1; waitClk(H - 2);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b0; waitClk(H);
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    waitClk(2); sdaM = 1'b0; waitClk(H - 2);
    sclM = 1'b1; waitClk(H);
    sdaM = 1'b1; waitClk(H);
  endtask

  task automatic writeBit(input logic b);
    waitClk(2); sdaM = b; waitClk(H - 2);
    sclM = 1'b1; waitClk(H);
    sclM = 1'b0;
  endtask

  task automatic readBit(output logic b);
    waitClk(2); sdaM = 1'b1; waitClk(H - 2);
    sclM = 1'b1; waitClk(H / 2);
    b = sdaIn; waitClk(H / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(ack);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) readBit(v[i]);
    writeBit(nack);
  endtask

  initial begin : watchdog
    waitClk(200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    waitClk(3);
    // R1: reset state
    check(sdaDriveLow == 1'b0, "R1 sda released", sdaDriveLow, 0);
    check({txnStart, rxValid, rdReq, stopSeen} == 4'b0, "R1 strobes idle",
          {txnStart, rxValid, rdReq, stopSeen}, 0);
    rstN = 1'b1;
    waitClk(5);

    // R3 R6: write with address 1010010 (strap 10), three bytes
    evQ.push_back(EV_TXN + 0);
    evQ.push_back(EV_RX + 256 + 8'h5A);
    evQ.push_back(EV_RX + 8'hC3);
    evQ.push_back(EV_RX + 8'h00);
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0100, a); check(a == 1'b0, "R3 address ack", a, 0);
    sendByte(8'h5A, a);        check(a == 1'b0, "R6 byte0 ack", a, 0);
    sendByte(8'hC3, a);        check(a == 1'b0, "R6 byte1 ack", a, 0);
    sendByte(8'h00, a);        check(a == 1'b0, "R6 byte2 ack", a, 0);
    stopCond();                // R2

    // R4: strap mismatch, data ignored
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0110, a); check(a == 1'b1, "R4 foreign address nack", a, 1);
    sendByte(8'h12, a);        check(a == 1'b1, "R4 data ignored", a, 1);
    stopCond();

    // R5: polling while busy, then after busy clears
    busy = 1'b1;
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0100, a); check(a == 1'b1, "R5 busy nack", a, 1);
    stopCond();
    busy = 1'b0;
    evQ.push_back(EV_TXN + 0);
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0100, a); check(a == 1'b0, "R5 poll ack after busy", a, 0);
    stopCond();

    // R9 R7 R8 R10: random read via repeated START
    evQ.push_back(EV_TXN + 0);
    evQ.push_back(EV_RX + 256 + 8'h07);
    evQ.push_back(EV_TXN + 1);
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0100, a); check(a == 1'b0, "R9 write address ack", a, 0);
    sendByte(8'h07, a);        check(a == 1'b0, "R9 pointer byte ack", a, 0);
    repStart();                // R11: START mid-transaction restarts address
    sendByte(8'b1010_0101, a); check(a == 1'b0, "R9 read address ack", a, 0);
    recvByte(1'b0, d); check(d == 8'h3C, "R7 R10 read byte0", d, 8'h3C);
    recvByte(1'b0, d); check(d == 8'h81, "R7 read byte1", d, 8'h81);
    recvByte(1'b1, d); check(d == 8'hF0, "R7 read byte2", d, 8'hF0);
    recvByte(1'b1, d); check(d == 8'hFF, "R8 silent after nack", d, 8'hFF);
    stopCond();
    check(rdPtr == 3, "R7 request count", rdPtr, 3);

    // R2: STOP in the middle of a byte, then a fresh read
    evQ.push_back(EV_TXN + 0);
    evQ.push_back(EV_STOP);
    evQ.push_back(EV_TXN + 1);
    evQ.push_back(EV_STOP);
    startCond();
    sendByte(8'b1010_0100, a); check(a == 1'b0, "R2 address ack", a, 0);
    for (int i = 0; i < 4; i++) writeBit(1'b1);
    stopCond();
    startCond();
    sendByte(8'b1010_0101, a); check(a == 1'b0, "R2 idle then read ack", a, 0);
    recvByte(1'b1, d); check(d == 8'h55, "R7 read after stop", d, 8'h55);
    stopCond();
    check(rdPtr == 4, "R7 total requests", rdPtr, 4);

    waitClk(10);
    check(evQ.size() == 0, "R2 all expected strobes seen", evQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule